// File: doc/BRIEF.md
# Word/Byte Parallel Host Port for a Multi-Channel Converter

This block sits between a host processor bus and a multi-channel converter core. The host sees an active-low chip select, an active-low read strobe and an active-low write strobe. It also drives a word/byte mode input and a 12-bit bidirectional data bus. The bus is modelled as an input vector, an output vector and a single output enable. In byte mode, data line 8 stops carrying data and becomes the host's select between the low byte and the high byte.

A read returns the latest conversion result, and in the high byte it also returns the channel that produced it. A write loads a 12-bit control word. In word mode the word arrives in one transfer. In byte mode it arrives in two transfers: the low byte is held in a staging register and the control word changes only when the high byte lands. The parameter `RES_BITS` selects a 12-bit or a 10-bit result. A 10-bit result is left-justified, so its two lowest bus bits read as zero.

All strobes pass through a synchroniser chain on the system clock. The output enable follows the raw pins, so the bus is released as soon as the host lets go.

Top module: `pbus_host_port`

## Requirements
- R1: In word mode (`word_mode`=1) a read drives the result on `d_out[11:0]`. With `RES_BITS`=10 the result sits on bits 11:2 and bits 1:0 read as 0.
- R2: In byte mode with `d_in[8]`=0, a read drives bits 7:0 of the left-justified word on `d_out[7:0]`, and `d_out[11:8]` is 0.
- R3: In byte mode with `d_in[8]`=1, a read drives the top four word bits on `d_out[3:0]` and the result channel on `d_out[5:4]`. Bits 7:6 and 11:8 are 0.
- R4: `d_oe` is 1 exactly while `cs_n` and `rd_n` are both 0. While `d_oe` is 0, `d_out` is all zero.
- R5: A word-mode write latches all 12 bits into `ctrl_word`, with a one-cycle `ctrl_load` pulse, within SYNC_STAGES+2 clocks after the strobe or chip select rises.
- R6: A byte-mode write with `d_in[8]`=0 leaves `ctrl_word` unchanged. A following write with `d_in[8]`=1 sets `ctrl_word` to {high[3:0], staged low byte}.
- R7: In a high-byte write, bits 7:4 never reach `ctrl_word`. If any of them is 1, `hi_err` is set and stays set until reset.
- R8: A write strobe while `cs_n` is 1 leaves `ctrl_word` and `hi_err` unchanged.
- R9: After reset, `ctrl_word` is 0, `hi_err` is 0, `ctrl_load` is 0 and `d_oe` is 0.
- R10: Once a read has been active for SYNC_STAGES+1 clocks, a change of `res_data` or `res_chan` does not change `d_out` until the read ends.
- R11: `ctrl_word` changes only in a cycle in which `ctrl_load` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| word_mode | input | 1 | 1 = word transfers, 0 = byte transfers |
| d_in | input | 12 | Bus value driven by the host; bit 8 selects the high byte in byte mode |
| d_out | output | 12 | Bus value driven by the port |
| d_oe | output | 1 | Output enable for `d_out` |
| res_data | input | RES_BITS | Latest conversion result from the core |
| res_chan | input | 2 | Channel of that result |
| ctrl_word | output | 12 | Control word for the core |
| ctrl_load | output | 1 | One-cycle pulse when `ctrl_word` updates |
| hi_err | output | 1 | Sticky flag: a high-byte write carried nonzero bits 7:4 |

## Verification
A wrong staging register does not show up after the low-byte write. It shows up only after the next high-byte write, as wrong bits 7:0 of `ctrl_word`, so each byte pair is checked as a unit. A misrouted format path shows on `d_out` as soon as the strobes settle, and a snapshot that is not frozen shows only when the result changes during a read. For that reason the result is changed while a read is held open. A wrong commit path shows within SYNC_STAGES+2 clocks of the strobe release, as a missing or stray `ctrl_load` or a wrong `ctrl_word`.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
   localparam int BUS_W  = 12;
   localparam int BYTE_W = 8;
   localparam int CH_W   = 2;
   typedef logic [BUS_W-1:0]  bus_t;
   typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
   parameter int          STAGES  = 2,
   parameter int          W       = 1,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   generate
      if (STAGES < 1) begin : g_bad
         $error("pbus_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= din;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/pbus_rd_fmt.sv
module pbus_rd_fmt
   import pbus_pkg::*;
#(
   parameter int RES_BITS = 12
) (
   input  logic [RES_BITS-1:0] res,
   input  logic [CH_W-1:0]     chan,
   input  logic                word_mode,
   input  logic                hi_sel,
   input  logic                oe,
   output bus_t                d_out
);
   localparam int PAD = BUS_W - RES_BITS;

   bus_t just;

   generate
      if (PAD == 0) begin : g_full
         assign just = res;
      end else begin : g_left
         assign just = {res, {PAD{1'b0}}};
      end
   endgenerate

   always_comb begin
      d_out = '0;
      if (oe) begin
         if (word_mode)   d_out = just;
         else if (hi_sel) d_out = {4'b0, 2'b0, chan, just[BUS_W-1:BYTE_W]};
         else             d_out = {4'b0, just[BYTE_W-1:0]};
      end
   end
endmodule

// File: rtl/pbus_wr_ctrl.sv
module pbus_wr_ctrl
   import pbus_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic act,
   input  bus_t data,
   input  logic wmode,
   output bus_t ctrl,
   output logic load,
   output logic err
);
   bus_t  wdat;
   logic  wm, pend;
   byte_t stage;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wdat  <= '0;
         wm    <= 1'b1;
         pend  <= 1'b0;
         stage <= '0;
         ctrl  <= '0;
         load  <= 1'b0;
         err   <= 1'b0;
      end else begin
         load <= 1'b0;
         if (act) begin
            wdat <= data;
            wm   <= wmode;
            pend <= 1'b1;
         end else if (pend) begin
            pend <= 1'b0;
            if (wm) begin
               ctrl <= wdat;
               load <= 1'b1;
            end else if (!wdat[BYTE_W]) begin
               stage <= wdat[BYTE_W-1:0];
            end else begin
               ctrl <= {wdat[3:0], stage};
               load <= 1'b1;
               if (|wdat[7:4]) err <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/pbus_host_port.sv
module pbus_host_port
   import pbus_pkg::*;
#(
   parameter int RES_BITS    = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_n,
   input  logic                rd_n,
   input  logic                wr_n,
   input  logic                word_mode,
   input  logic [11:0]         d_in,
   output logic [11:0]         d_out,
   output logic                d_oe,
   input  logic [RES_BITS-1:0] res_data,
   input  logic [1:0]          res_chan,
   output logic [11:0]         ctrl_word,
   output logic                ctrl_load,
   output logic                hi_err
);
   generate
      if (RES_BITS != 12 && RES_BITS != 10) begin : g_bad_res
         $error("pbus_host_port: RES_BITS must be 10 or 12");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pbus_host_port: SYNC_STAGES must be at least 2");
      end
   endgenerate

   localparam int SNAP_W = RES_BITS + CH_W;

   logic [2:0] strb_s;
   logic       cs_s, rd_s, wr_s;
   logic [BUS_W:0] dly_in;

   pbus_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b111)) u_strb (
      .clk(clk), .rst_n(rst_n), .din({cs_n, rd_n, wr_n}), .dout(strb_s));
   assign {cs_s, rd_s, wr_s} = strb_s;

   pbus_sync #(.STAGES(SYNC_STAGES), .W(BUS_W+1), .RST_VAL('0)) u_dly (
      .clk(clk), .rst_n(rst_n), .din({word_mode, d_in}), .dout(dly_in));

   logic rd_act_s, wr_act_s;
   assign rd_act_s = !cs_s && !rd_s;
   assign wr_act_s = !cs_s && !wr_s;

   logic [SNAP_W-1:0] snap;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         snap <= '0;
      else if (!rd_act_s) snap <= {res_chan, res_data};
   end

   assign d_oe = !cs_n && !rd_n;

   pbus_rd_fmt #(.RES_BITS(RES_BITS)) u_fmt (
      .res(snap[RES_BITS-1:0]), .chan(snap[SNAP_W-1:RES_BITS]),
      .word_mode(word_mode), .hi_sel(d_in[BYTE_W]), .oe(d_oe), .d_out(d_out));

   pbus_wr_ctrl u_wr (
      .clk(clk), .rst_n(rst_n), .act(wr_act_s),
      .data(dly_in[BUS_W-1:0]), .wmode(dly_in[BUS_W]),
      .ctrl(ctrl_word), .load(ctrl_load), .err(hi_err));
endmodule

// File: rtl/pbus_host_port_chk.sv
module pbus_host_port_chk #(
   parameter int RES_BITS = 12
) (
   input logic        clk,
   input logic        rst_n,
   input logic        cs_n,
   input logic        rd_n,
   input logic        word_mode,
   input logic [11:0] d_in,
   input logic [11:0] d_out,
   input logic        d_oe,
   input logic [11:0] ctrl_word,
   input logic        ctrl_load,
   input logic        hi_err
);
   assert_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || rd_n) |-> (!d_oe && d_out == 12'h000));

   assert_byte_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (d_oe && !word_mode) |-> d_out[11:8] == 4'h0);

   assert_hi_pad_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (d_oe && !word_mode && d_in[8]) |-> d_out[7:6] == 2'b00);

   assert_lsb_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (RES_BITS == 10 && d_oe && word_mode) |-> d_out[1:0] == 2'b00);

   assert_sticky_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hi_err) |-> hi_err);

   assert_ctrl_only_on_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_word != $past(ctrl_word)) |-> ctrl_load);
endmodule

bind pbus_host_port pbus_host_port_chk #(.RES_BITS(RES_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .word_mode(word_mode),
   .d_in(d_in), .d_out(d_out), .d_oe(d_oe), .ctrl_word(ctrl_word),
   .ctrl_load(ctrl_load), .hi_err(hi_err));

// File: tb/sim_pbus_host_port.sv
module sim_pbus_host_port;
   logic clk = 0;
   logic rst_n = 0;
   logic cs_n = 1, rd_n = 1, wr_n = 1, word_mode = 1;
   logic [11:0] d_in = '0;
   logic [11:0] res = '0;
   logic [1:0]  chan = '0;
   logic [11:0] d_out0, d_out1, ctrl0, ctrl1;
   logic        oe0, oe1, ld0, ld1, err0, err1;

   int total = 0, bad = 0;
   logic [11:0] m_ctrl = '0;
   logic [7:0]  m_stage = '0;
   logic        m_err = 0;
   int          load_seen = 0;

   always #5 clk = ~clk;

   pbus_host_port #(.RES_BITS(12)) u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .word_mode(word_mode), .d_in(d_in), .d_out(d_out0), .d_oe(oe0),
      .res_data(res), .res_chan(chan), .ctrl_word(ctrl0), .ctrl_load(ld0),
      .hi_err(err0));

   pbus_host_port #(.RES_BITS(10)) u1 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .word_mode(word_mode), .d_in(d_in), .d_out(d_out1), .d_oe(oe1),
      .res_data(res[9:0]), .res_chan(chan), .ctrl_word(ctrl1), .ctrl_load(ld1),
      .hi_err(err1));

   always @(posedge clk) if (ld0) load_seen++;

   function automatic logic [11:0] exp_rd(input logic [11:0] r, input logic [1:0] c,
                                          input logic wm, input logic hb, input bit ten);
      logic [11:0] j;
      j = ten ? {r[9:0], 2'b00} : r;
      if (wm)      return j;
      else if (hb) return {6'b0, c, j[11:8]};
      else         return {4'b0, j[7:0]};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_read(input logic wm, input logic hb, input string req);
      word_mode = wm; d_in = {3'b0, hb, 8'h00};
      cs_n = 0; rd_n = 0;
      ticks(5);
      check({req, " u0"}, d_out0, exp_rd(res, chan, wm, hb, 0));
      check({req, " u1"}, d_out1, exp_rd(res, chan, wm, hb, 1));
      check("R4 oe", {oe0, oe1}, 2'b11);
      rd_n = 1; cs_n = 1;
      ticks(2);
   endtask

   task automatic do_write(input logic wm, input logic [11:0] d, input logic sel);
      word_mode = wm; d_in = d;
      if (sel) cs_n = 0;
      ticks(1);
      wr_n = 0;
      ticks(3);
      wr_n = 1;
      ticks(1);
      cs_n = 1;
      ticks(5);
      if (sel) begin
         if (wm) m_ctrl = d;
         else if (!d[8]) m_stage = d[7:0];
         else begin
            m_ctrl = {d[3:0], m_stage};
            if (|d[7:4]) m_err = 1;
         end
      end
   endtask

   initial begin
      #200000;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      process::self().srandom(32'd7);
      ticks(3);
      // R9 reset state
      check("R9 ctrl", {ctrl0, ctrl1}, 24'h0);
      check("R9 err/ld/oe", {err0, ld0, oe0, err1}, 4'h0);
      rst_n = 1;
      ticks(2);

      // R1 R2 R3 directed reads
      res = 12'hABC; chan = 2'd2;
      do_read(1, 0, "R1 word");
      do_read(0, 0, "R2 low byte");
      do_read(0, 1, "R3 high byte");
      res = 12'hFFF; chan = 2'd3;
      do_read(0, 1, "R3 all ones");

      // R4 idle bus
      cs_n = 0; rd_n = 1; ticks(2);
      check("R4 idle", {oe0, d_out0, d_out1}, 25'h0);
      cs_n = 1; rd_n = 0; ticks(2);
      check("R4 no cs", {oe0, d_out0}, 13'h0);
      rd_n = 1; ticks(1);

      // R10 freeze during read
      res = 12'h123; chan = 2'd1; word_mode = 1; ticks(2);
      cs_n = 0; rd_n = 0; ticks(5);
      res = 12'h9E7; chan = 2'd0; ticks(3);
      check("R10 frozen", d_out0, 12'h123);
      rd_n = 1; cs_n = 1; ticks(4);

      // R5 word write, timing of load pulse
      load_seen = 0;
      do_write(1, 12'h5A3, 1);
      check("R5 ctrl", ctrl0, 12'h5A3);
      check("R5 ctrl 10b", ctrl1, 12'h5A3);
      check("R5 one load", load_seen, 1);

      // R6 byte pair
      load_seen = 0;
      do_write(0, 12'h0C7, 1);
      check("R6 low staged only", ctrl0, 12'h5A3);
      check("R6 no load yet", load_seen, 0);
      do_write(0, 12'h109, 1);
      check("R6 pair", ctrl0, 12'h9C7);
      check("R7 no err", err0, 0);

      // R8 write without chip select
      do_write(1, 12'h777, 0);
      check("R8 ignored", ctrl0, 12'h9C7);

      // R7 nonzero upper nibble
      do_write(0, 12'h1F4, 1);
      check("R7 ctrl", ctrl0, 12'h4C7);
      check("R7 err", {err0, err1}, 2'b11);
      do_write(1, 12'h000, 1);
      check("R7 sticky", err0, 1);

      // randomized mix
      for (int k = 0; k < 60; k++) begin
         int op;
         op = $urandom_range(0, 3);
         if (op == 0) begin
            res = 12'($urandom); chan = 2'($urandom); ticks(3);
            do_read(1'($urandom), 1'($urandom), "R1 R2 R3 rand read");
         end else begin
            logic wm; logic [11:0] d;
            wm = 1'($urandom);
            d  = 12'($urandom);
            if (!wm && op == 1) d[7:4] = 4'h0;
            do_write(wm, d, op != 3);
            check("R5 R6 R8 rand ctrl", ctrl0, m_ctrl);
            check("R7 rand err", err0, m_err);
         end
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule